// File: doc/BRIEF.md
# System Clock Source Switch Sequencer

This block decides when and how the system clock moves between three sources: the internal 16 MHz oscillator, an external oscillator and a PLL. A one-cycle start pulse carries a request made of a source code and a bus prescaler code. The block then checks the request against the frequency limits of the present voltage range and waits for the chosen source to report ready. It drives the select of a glitch-free clock mux, which lies outside this block, and it drives the active prescaler code.

A switch can cause a large jump in bus frequency. This happens when the PLL is entered with a bus clock above 80 MHz, or when the PLL is left while the bus clock is above 80 MHz. For such a switch the block first sets the bus clock to divide-by-2, then changes the source, and then waits at least 1 µs before it applies the requested prescaler. The block counts the wait in cycles of its own clock, which is an always-running reference clock. The PLL and external frequencies are inputs given in MHz. The oscillators, the PLL and the mux cell are modelled only by these inputs, the ready inputs and the select output.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset the select is the internal oscillator (code 0), the prescaler code is 0, and busy and error are both low.
- R2: A request is rejected if the source frequency exceeds the limit for the present range. The external oscillator is limited to 48 MHz in the high range (`low_range_i`=0) and to 26 MHz in the low range. The PLL is limited to 170 MHz with boost, to 150 MHz without boost and to 26 MHz in the low range. On a rejected request the error flag is set, busy stays low, and the select and prescaler keep their values.
- R3: Source code 3 and prescaler codes above 9 are rejected in the same way as in R2. Source codes are 0 for internal, 1 for external and 2 for PLL. Prescaler code n divides by 2^n.
- R4: An accepted request that needs no transition step raises busy for exactly one cycle. The source and the prescaler are applied together on the edge where busy falls.
- R5: While the ready bit of the requested source (`rdy_i[src]`) is low, busy stays high and the select and prescaler do not change.
- R6: A request that enters the PLL, with the PLL frequency shifted right by the requested code above 80, runs a transition step. One cycle after the start edge the prescaler becomes 1. One cycle later the select changes. Exactly 16 cycles after that, with the 16 MHz default reference clock, the final prescaler is applied and busy falls.
- R7: A request that leaves the PLL while the present bus clock (PLL frequency shifted right by the active code) is above 80 MHz runs the same transition step as R6.
- R8: A start pulse that arrives while busy is high has no effect on the switch in progress.
- R9: An accepted request clears the error flag on its start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| src_req_i | input | 2 | Requested source: 0 internal, 1 external, 2 PLL |
| presc_req_i | input | 4 | Requested bus prescaler code (divide by 2^code) |
| low_range_i | input | 1 | Low voltage range selected |
| boost_i | input | 1 | Boost mode of the high range |
| ext_mhz_i | input | 8 | External oscillator frequency in MHz |
| pll_mhz_i | input | 8 | PLL output frequency in MHz |
| rdy_i | input | 3 | Ready bit for each source, indexed by source code |
| clk_sel_o | output | 2 | Select for the glitch-free clock mux |
| presc_o | output | 4 | Active bus prescaler code |
| busy_o | output | 1 | A switch is in progress |
| err_o | output | 1 | The last request was rejected |

## Verification
The bench steps through PLL and external frequencies, both ranges, boost on and off, every source code and a mix of prescaler codes. This puts limits exactly at 26, 48, 150 and 170 MHz and bus clocks just above and below 80 MHz in both directions.

Each of the following faults shows up at a specific place. A design that compares against the limit or the threshold the wrong way accepts a request that sits exactly on a limit, or skips a needed ramp. A design that leaves out the divide-by-2 step applies the final code on the same edge as the source change. An off-by-one in the dwell counter moves the edge where busy falls by one cycle.

Held-off ready bits and start pulses sent during a switch are used to expose a design that switches before the source is ready, or that latches a second request while busy.

// File: rtl/clk_sw_pkg.sv
package clk_sw_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_BAD = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_HALVE = 2'd2,
    ST_DWELL = 2'd3
  } seq_st_e;
endpackage

// File: rtl/clk_sw_plan.sv
module clk_sw_plan
  import clk_sw_pkg::*;
#(
  parameter int FREQ_W        = 8,
  parameter int PRESC_W       = 4,
  parameter int PRESC_MAX     = 9,
  parameter int INT_MHZ       = 16,
  parameter int HI_MHZ        = 80,
  parameter int LIM_EXT_HI    = 48,
  parameter int LIM_EXT_LO    = 26,
  parameter int LIM_PLL_BOOST = 170,
  parameter int LIM_PLL_NORM  = 150,
  parameter int LIM_PLL_LO    = 26
) (
  input  logic [1:0]         cur_src_i,
  input  logic [PRESC_W-1:0] cur_presc_i,
  input  logic [1:0]         req_src_i,
  input  logic [PRESC_W-1:0] req_presc_i,
  input  logic               low_range_i,
  input  logic               boost_i,
  input  logic [FREQ_W-1:0]  ext_mhz_i,
  input  logic [FREQ_W-1:0]  pll_mhz_i,
  output logic               ok_o,
  output logic               trans_o
);
  localparam logic [FREQ_W-1:0] INT_F   = FREQ_W'(INT_MHZ);
  localparam logic [FREQ_W-1:0] HI_F    = FREQ_W'(HI_MHZ);
  localparam logic [FREQ_W-1:0] EXT_HI  = FREQ_W'(LIM_EXT_HI);
  localparam logic [FREQ_W-1:0] EXT_LO  = FREQ_W'(LIM_EXT_LO);
  localparam logic [FREQ_W-1:0] PLL_BST = FREQ_W'(LIM_PLL_BOOST);
  localparam logic [FREQ_W-1:0] PLL_NRM = FREQ_W'(LIM_PLL_NORM);
  localparam logic [FREQ_W-1:0] PLL_LO  = FREQ_W'(LIM_PLL_LO);
  localparam logic [PRESC_W-1:0] PMAX   = PRESC_W'(PRESC_MAX);

  logic [FREQ_W-1:0] req_f, lim_f, bus_new, bus_cur;
  logic              src_ok, enter_hi, leave_hi;

  always_comb begin
    req_f  = '0;
    lim_f  = '0;
    src_ok = 1'b1;
    unique case (src_e'(req_src_i))
      SRC_INT: begin
        req_f = INT_F;
        lim_f = INT_F;
      end
      SRC_EXT: begin
        req_f = ext_mhz_i;
        lim_f = low_range_i ? EXT_LO : EXT_HI;
      end
      SRC_PLL: begin
        req_f = pll_mhz_i;
        lim_f = low_range_i ? PLL_LO : (boost_i ? PLL_BST : PLL_NRM);
      end
      default: src_ok = 1'b0;
    endcase
  end

  assign bus_new = pll_mhz_i >> req_presc_i;
  assign bus_cur = pll_mhz_i >> cur_presc_i;

  assign enter_hi = (cur_src_i != SRC_PLL) && (req_src_i == SRC_PLL) && (bus_new > HI_F);
  assign leave_hi = (cur_src_i == SRC_PLL) && (req_src_i != SRC_PLL) && (bus_cur > HI_F);

  assign ok_o    = src_ok && (req_presc_i <= PMAX) && (req_f <= lim_f);
  assign trans_o = enter_hi || leave_hi;
endmodule

// File: rtl/clk_sw_dwell.sv
module clk_sw_dwell #(
  parameter int DWELL_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(DWELL_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  generate
    if (DWELL_CYC <= 1) begin : g_single
      assign cnt_q  = '0;
      assign done_o = run_i;
    end else begin : g_count
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 cnt_q <= '0;
        else if (clr_i)              cnt_q <= '0;
        else if (run_i && !done_o)   cnt_q <= cnt_q + 1'b1;
      end
      assign done_o = run_i && (cnt_q == LAST);
    end
  endgenerate

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clk_sw_pkg::*;
#(
  parameter int FREQ_W    = 8,
  parameter int PRESC_W   = 4,
  parameter int PRESC_MAX = 9,
  parameter int REF_MHZ   = 16,
  parameter int DWELL_NS  = 1000,
  parameter int HI_MHZ    = 80
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         src_req_i,
  input  logic [PRESC_W-1:0] presc_req_i,
  input  logic               low_range_i,
  input  logic               boost_i,
  input  logic [FREQ_W-1:0]  ext_mhz_i,
  input  logic [FREQ_W-1:0]  pll_mhz_i,
  input  logic [2:0]         rdy_i,
  output logic [1:0]         clk_sel_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               busy_o,
  output logic               err_o
);
  localparam int DWELL_RAW = (REF_MHZ * DWELL_NS + 999) / 1000;
  localparam int DWELL_CYC = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
  localparam logic [PRESC_W-1:0] HALF = PRESC_W'(1);

  seq_st_e            st_q;
  logic [1:0]         sel_q, tgt_src_q;
  logic [PRESC_W-1:0] presc_q, tgt_presc_q;
  logic               err_q, trans_q;
  logic               req_ok, req_trans, tgt_rdy, dwell_done;

  clk_sw_plan #(
    .FREQ_W   (FREQ_W),
    .PRESC_W  (PRESC_W),
    .PRESC_MAX(PRESC_MAX),
    .HI_MHZ   (HI_MHZ)
  ) i_plan (
    .cur_src_i  (sel_q),
    .cur_presc_i(presc_q),
    .req_src_i  (src_req_i),
    .req_presc_i(presc_req_i),
    .low_range_i(low_range_i),
    .boost_i    (boost_i),
    .ext_mhz_i  (ext_mhz_i),
    .pll_mhz_i  (pll_mhz_i),
    .ok_o       (req_ok),
    .trans_o    (req_trans)
  );

  clk_sw_dwell #(.DWELL_CYC(DWELL_CYC)) i_dwell (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == ST_HALVE),
    .run_i (st_q == ST_DWELL),
    .done_o(dwell_done)
  );

  always_comb begin
    unique case (tgt_src_q)
      2'd0:    tgt_rdy = rdy_i[0];
      2'd1:    tgt_rdy = rdy_i[1];
      2'd2:    tgt_rdy = rdy_i[2];
      default: tgt_rdy = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      sel_q       <= SRC_INT;
      presc_q     <= '0;
      err_q       <= 1'b0;
      trans_q     <= 1'b0;
      tgt_src_q   <= SRC_INT;
      tgt_presc_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (req_ok) begin
            err_q       <= 1'b0;
            tgt_src_q   <= src_req_i;
            tgt_presc_q <= presc_req_i;
            trans_q     <= req_trans;
            st_q        <= ST_WAIT;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_WAIT: if (tgt_rdy) begin
          if (trans_q) begin
            presc_q <= HALF;
            st_q    <= ST_HALVE;
          end else begin
            sel_q   <= tgt_src_q;
            presc_q <= tgt_presc_q;
            st_q    <= ST_IDLE;
          end
        end
        ST_HALVE: begin
          sel_q <= tgt_src_q;
          st_q  <= ST_DWELL;
        end
        ST_DWELL: if (dwell_done) begin
          presc_q <= tgt_presc_q;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_sel_o = sel_q;
  assign presc_o   = presc_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign err_o     = err_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |=> ($stable(sel_q) && $stable(presc_q)));

  assert_reject_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !busy_o);

  assert_wait_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !tgt_rdy) |=> ($stable(sel_q) && $stable(presc_q) && busy_o));

  assert_half_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trans_q && (sel_q != $past(sel_q))) |-> (presc_q == HALF));

  assert_dwell_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DWELL && !dwell_done) |=> (presc_q == HALF));

  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(tgt_src_q) && $stable(tgt_presc_q)));
endmodule

// File: tb/test_clk_switch_seq.sv
`timescale 1ns/1ps
module test_clk_switch_seq;
  localparam int DW = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] src_req_i = 2'd0;
  logic [3:0] presc_req_i = 4'd0;
  logic       low_range_i = 1'b0;
  logic       boost_i = 1'b0;
  logic [7:0] ext_mhz_i = 8'd24;
  logic [7:0] pll_mhz_i = 8'd100;
  logic [2:0] rdy_i = 3'b111;
  logic [1:0] clk_sel_o;
  logic [3:0] presc_o;
  logic       busy_o, err_o;

  int n_chk = 0;
  int n_bad = 0;
  int m_src = 0;
  int m_presc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clk_switch_seq i_clk_switch_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .src_req_i(src_req_i),
    .presc_req_i(presc_req_i), .low_range_i(low_range_i), .boost_i(boost_i),
    .ext_mhz_i(ext_mhz_i), .pll_mhz_i(pll_mhz_i), .rdy_i(rdy_i),
    .clk_sel_o(clk_sel_o), .presc_o(presc_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_req(int s, int p, int hold, bit poke);
    int fs, lim;
    bit ok, need;
    string tg;
    fs  = (s == 0) ? 16 : (s == 1) ? int'(ext_mhz_i) : (s == 2) ? int'(pll_mhz_i) : 0;
    lim = (s == 1) ? (low_range_i ? 26 : 48) :
          (s == 2) ? (low_range_i ? 26 : (boost_i ? 170 : 150)) : 255;
    ok  = (s < 3) && (p <= 9) && (fs <= lim);
    need = ok && (((m_src != 2) && (s == 2) && ((int'(pll_mhz_i) >> p) > 80)) ||
                  ((m_src == 2) && (s != 2) && ((int'(pll_mhz_i) >> m_presc) > 80)));
    tg = (m_src == 2) ? "R7" : "R6";
    if (hold > 0 && ok) rdy_i[s] = 1'b0;
    @(negedge clk_i);
    src_req_i = 2'(s); presc_req_i = 4'(p); start_i = 1'b1;
    step();
    if (!ok) begin
      if (s == 3 || p > 9) begin
        chk("R3", "err", int'(err_o), 1); chk("R3", "busy", int'(busy_o), 0);
        chk("R3", "sel", int'(clk_sel_o), m_src); chk("R3", "presc", int'(presc_o), m_presc);
      end else begin
        chk("R2", "err", int'(err_o), 1); chk("R2", "busy", int'(busy_o), 0);
        chk("R2", "sel", int'(clk_sel_o), m_src); chk("R2", "presc", int'(presc_o), m_presc);
      end
      return;
    end
    chk("R9", "err", int'(err_o), 0);
    chk("R4", "busy", int'(busy_o), 1);
    chk("R4", "sel held", int'(clk_sel_o), m_src);
    if (poke) begin
      start_i = 1'b1; src_req_i = 2'((s + 1) % 3); presc_req_i = 4'd5;
    end
    if (hold > 0) begin
      repeat (hold) begin
        step();
        chk("R5", "busy", int'(busy_o), 1);
        chk("R5", "sel", int'(clk_sel_o), m_src);
        chk("R5", "presc", int'(presc_o), m_presc);
      end
      rdy_i[s] = 1'b1;
    end
    step();
    if (!need) begin
      chk("R4", "busy", int'(busy_o), 0);
      chk("R4", "sel", int'(clk_sel_o), s);
      chk("R4", "presc", int'(presc_o), p);
    end else begin
      chk(tg, "half", int'(presc_o), 1);
      chk(tg, "sel old", int'(clk_sel_o), m_src);
      step();
      chk(tg, "sel new", int'(clk_sel_o), s);
      chk(tg, "half", int'(presc_o), 1);
      for (int k = 1; k < DW; k++) begin
        step();
        chk(tg, "dwell presc", int'(presc_o), 1);
        chk(tg, "dwell busy", int'(busy_o), 1);
      end
      step();
      chk(tg, "final presc", int'(presc_o), p);
      chk(tg, "busy end", int'(busy_o), 0);
      chk(tg, "sel", int'(clk_sel_o), s);
    end
    m_src = s; m_presc = p;
    if (poke) begin
      step();
      chk("R8", "sel", int'(clk_sel_o), s);
      chk("R8", "presc", int'(presc_o), p);
      chk("R8", "busy", int'(busy_o), 0);
      chk("R8", "err", int'(err_o), 0);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int plls[4];
    int exts[2];
    int pcs[4];
    plls = '{170, 150, 100, 26};
    exts = '{48, 24};
    pcs  = '{0, 1, 2, 10};
    repeat (3) @(negedge clk_i);
    chk("R1", "sel", int'(clk_sel_o), 0);
    chk("R1", "presc", int'(presc_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "err", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // Directed: enter PLL at 170 boost, poke while busy, leave PLL high.
    pll_mhz_i = 8'd170; boost_i = 1'b1; low_range_i = 1'b0;
    run_req(2, 0, 0, 1'b1);
    run_req(0, 2, 2, 1'b0);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 2; b++)
        for (int v = 0; v < 2; v++)
          for (int o = 0; o < 2; o++)
            for (int s = 0; s < 4; s++)
              for (int q = 0; q < 4; q++) begin
                pll_mhz_i = 8'(plls[a]); ext_mhz_i = 8'(exts[b]);
                low_range_i = v[0]; boost_i = o[0];
                run_req(s, pcs[q], (s == 2 && q == 1) ? 3 : 0, (q == 0));
              end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule